// File: doc/BRIEF.md
# Sync-Word Detector with Bit FIFO Fill

This block sits in the receive path of a packet radio, after demodulation and clock recovery. It takes clean received bits, each qualified by a one-cycle valid strobe, and hunts for a synchronization word. The word is either two bytes, a fixed 2Dh byte then a programmable byte, or one byte, the programmable byte alone. Once the word is found, every following bit is shifted into a 16-bit receive FIFO. A bypass setting stores every valid bit without any hunt.

A host drains the FIFO one byte at a time through a read strobe and watches two flags. The level flag is high while the stored bit count is at or above a programmable threshold. The sticky overflow flag records that a bit arrived while the FIFO was full. Dropping the fill-enable input for at least one cycle empties the FIFO, clears both the lock and the overflow flag, and restarts the hunt once the input returns high.

Top module: `sync_fill_rx`

## Requirements
- R1: With `two_byte`=1 the block locks when the 16 most recent valid bits, oldest bit compared to bit 15, equal {8'h2D, `sync_lo`}. It needs at least 16 valid bits received since fill-enable rose.
- R2: With `two_byte`=0 the block locks when the 8 most recent valid bits, oldest compared to bit 7, equal `sync_lo`. It needs at least 8 valid bits received since fill-enable rose.
- R3: The bits of the sync word are not stored. `synced` goes high in the cycle after the last word bit, with `fill_cnt` still 0. Only bits after that bit enter the FIFO.
- R4: Once locked, the hunt stops. Later occurrences of the word are stored as ordinary data, and `synced` stays high until `fill_en` goes low.
- R5: With `always_fill`=1 and `fill_en`=1, every valid bit is stored with no word match. With `fill_en`=0, no bit is ever stored.
- R6: While `fill_en` is low the FIFO is empty, `synced` and `ovf` are 0, and the count of bits seen by the hunt is reset. Bits received before the re-arm therefore cannot complete a match.
- R7: The FIFO holds 16 bits, and `fill_cnt` gives the number held, from 0 to 16.
- R8: `rd_data` shows the oldest 8 stored bits, with bit 7 the oldest. A `rd_req` cycle with `fill_cnt` >= 8 removes them. A `rd_req` with fewer than 8 bits held is ignored. A push in the same cycle as a removal is kept.
- R9: `lvl_irq` is 1 exactly when `fill_cnt` >= `lvl_thresh`, so a threshold of 0 keeps it high.
- R10: A bit to be stored while 16 bits are held is discarded and sets `ovf`. `ovf` stays set until `fill_en` goes low, and the stored bits are unchanged.
- R11: Cycles with `bit_vld`=0 change neither the FIFO nor the hunt state, whatever `bit_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | One-cycle strobe qualifying `bit_in` |
| fill_en | input | 1 | Arms the hunt and the FIFO; low clears them |
| two_byte | input | 1 | 1: two-byte word, 0: one-byte word |
| always_fill | input | 1 | 1: store all bits without a hunt |
| sync_lo | input | 8 | Programmable word byte |
| lvl_thresh | input | 5 | Bit count that raises `lvl_irq` |
| rd_req | input | 1 | Remove the oldest byte |
| rd_data | output | 8 | Oldest stored byte, bit 7 oldest |
| fill_cnt | output | 5 | Bits held in the FIFO |
| lvl_irq | output | 1 | Fill level at or above threshold |
| ovf | output | 1 | Sticky overflow flag |
| synced | output | 1 | Sync word found since arming |

## Verification
The bench sends sync words for a spread of programmable bytes in both word lengths, starting right at re-arm. A design that matched early, or that stored the word bits, would show `synced` one bit too soon or a nonzero count. An all-zero word sent after re-arm shows whether the count of bits seen is reset: without that reset, the cleared history would match after one bit. Sweeping every threshold against every count catches off-by-one level compares. Filling to capacity, then mixing reads with a simultaneous push, exposes lost pushes, bits that overwrite on overflow, and short reads that remove data anyway.

// File: rtl/sync_fill_pkg.sv
package sync_fill_pkg;
    localparam int          WORD_W  = 16;
    localparam int          SEEN_W  = 5;
    localparam logic [7:0]  SYNC_HI = 8'h2D;

    typedef struct packed {
        logic [WORD_W-1:0] hist;
        logic [SEEN_W-1:0] seen;
        logic              locked;
    } hunt_t;
endpackage

// File: rtl/sync_hunt.sv
module sync_hunt
    import sync_fill_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       bit_in,
    input  logic       bit_vld,
    input  logic       two_byte,
    input  logic       always_fill,
    input  logic [7:0] sync_lo,
    output logic       store,
    output logic       locked
);
    localparam logic [SEEN_W-1:0] SEEN_MAX = SEEN_W'(WORD_W);
    localparam logic [SEEN_W-1:0] NEED_ONE = SEEN_W'(8);

    hunt_t h_d, h_q;
    logic [WORD_W-1:0] hist_n;
    logic [SEEN_W-1:0] seen_n;
    logic              match;

    always_comb begin
        h_d    = h_q;
        store  = 1'b0;
        hist_n = {h_q.hist[WORD_W-2:0], bit_in};
        seen_n = (h_q.seen == SEEN_MAX) ? h_q.seen : h_q.seen + 1'b1;
        match  = two_byte ? ((hist_n == {SYNC_HI, sync_lo}) && (seen_n == SEEN_MAX))
                          : ((hist_n[7:0] == sync_lo) && (seen_n >= NEED_ONE));
        if (!arm) begin
            h_d = '0;
        end else if (bit_vld) begin
            if (always_fill || h_q.locked) begin
                store = 1'b1;
            end else begin
                h_d.hist = hist_n;
                h_d.seen = seen_n;
                if (match) h_d.locked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign locked = h_q.locked;

    p_stay_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && arm) |=> locked);
    p_rearm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (!locked && h_q.seen == '0));
    p_idle_hunt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !bit_vld) |=> $stable(h_q));
endmodule

// File: rtl/bit_fifo.sv
module bit_fifo #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          push_bit,
    input  logic          pop_req,
    output logic [CW-1:0] cnt,
    output logic [7:0]    head,
    output logic          ovf
);
    localparam logic [CW-1:0] BYTE_C  = CW'(8);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [CW-1:0]    cnt;
        logic             ovf;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_pop;

    always_comb begin
        f_d    = f_q;
        do_pop = pop_req && (f_q.cnt >= BYTE_C);
        if (clr) begin
            f_d = '0;
        end else begin
            if (do_pop) begin
                f_d.mem = f_q.mem >> 8;
                f_d.cnt = f_q.cnt - BYTE_C;
            end
            if (push) begin
                if (f_d.cnt < DEPTH_C) begin
                    f_d.mem[f_d.cnt[IW-1:0]] = push_bit;
                    f_d.cnt = f_d.cnt + 1'b1;
                end else begin
                    f_d.ovf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    for (genvar i = 0; i < 8; i++) begin : g_head
        assign head[7-i] = f_q.mem[i];
    end
    assign cnt = f_q.cnt;
    assign ovf = f_q.ovf;

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_C);
    p_ovf_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_req && !clr && cnt == DEPTH_C) |=> (ovf && $stable(f_q.mem) && cnt == DEPTH_C));
    p_pop_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push && !clr && cnt >= BYTE_C) |=> (cnt == $past(cnt) - BYTE_C));
    p_short_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push && !clr && cnt < BYTE_C) |=> $stable(cnt));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf));
    p_idle_fifo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop_req && !clr) |=> ($stable(cnt) && $stable(f_q.mem)));
endmodule

// File: rtl/sync_fill_rx.sv
module sync_fill_rx #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_in,
    input  logic          bit_vld,
    input  logic          fill_en,
    input  logic          two_byte,
    input  logic          always_fill,
    input  logic [7:0]    sync_lo,
    input  logic [CW-1:0] lvl_thresh,
    input  logic          rd_req,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] fill_cnt,
    output logic          lvl_irq,
    output logic          ovf,
    output logic          synced
);
    logic store;

    sync_hunt u_hunt (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (fill_en),
        .bit_in      (bit_in),
        .bit_vld     (bit_vld),
        .two_byte    (two_byte),
        .always_fill (always_fill),
        .sync_lo     (sync_lo),
        .store       (store),
        .locked      (synced)
    );

    bit_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!fill_en),
        .push     (store),
        .push_bit (bit_in),
        .pop_req  (rd_req),
        .cnt      (fill_cnt),
        .head     (rd_data),
        .ovf      (ovf)
    );

    assign lvl_irq = (fill_cnt >= lvl_thresh);

    p_hold_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !always_fill && !synced && !rd_req) |=> (fill_cnt == $past(fill_cnt)));
    p_bypass_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && always_fill && bit_vld && !rd_req && fill_cnt == '0) |=> (fill_cnt == CW'(1)));
endmodule

// File: tb/sync_fill_rx_bench.sv
module sync_fill_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0, bit_vld = 1'b0, fill_en = 1'b0;
    logic       two_byte = 1'b0, always_fill = 1'b0, rd_req = 1'b0;
    logic [7:0] sync_lo = 8'hD4;
    logic [4:0] lvl_thresh = 5'd8;
    logic [7:0] rd_data;
    logic [4:0] fill_cnt;
    logic       lvl_irq, ovf, synced;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_fill_rx u_sync_fill_rx (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .fill_en(fill_en), .two_byte(two_byte), .always_fill(always_fill),
        .sync_lo(sync_lo), .lvl_thresh(lvl_thresh), .rd_req(rd_req),
        .rd_data(rd_data), .fill_cnt(fill_cnt), .lvl_irq(lvl_irq),
        .ovf(ovf), .synced(synced)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_in = b; bit_vld = 1'b1;
        @(negedge clk); bit_vld = 1'b0; bit_in = ~b;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) send_bit(v[k]);
    endtask

    task automatic rearm();
        @(negedge clk); fill_en = 1'b0;
        @(negedge clk); fill_en = 1'b1;
    endtask

    task automatic read_byte();
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset count", fill_cnt, 0);
        chk("R6 reset synced", synced, 0);
        chk("R10 reset ovf", ovf, 0);
        rst_n = 1'b1;

        // R1 / R2 / R3: word match for many programmable bytes, both lengths
        for (int two = 0; two < 2; two++) begin
            for (int i = 0; i < 8; i++) begin
                logic [7:0]  lo, pay;
                logic [15:0] word;
                int          wl;
                lo   = 8'(i * 37 + 11);
                pay  = lo ^ 8'(8'hA5 + i);
                wl   = two ? 16 : 8;
                word = two ? {8'h2D, lo} : {8'h00, lo};
                @(negedge clk); two_byte = two[0]; always_fill = 1'b0; sync_lo = lo;
                rearm();
                send_bits(word >> 1, wl - 1);
                chk(two ? "R1 no early lock" : "R2 no early lock", synced, 0);
                send_bit(word[0]);
                chk(two ? "R1 lock" : "R2 lock", synced, 1);
                chk("R3 word not stored", fill_cnt, 0);
                send_bits({8'h00, pay}, 8);
                chk("R3 payload count", fill_cnt, 8);
                chk("R8 payload byte", rd_data, pay);
                read_byte();
                chk("R8 read empties", fill_cnt, 0);
            end
        end

        // R6: all-zero one-byte word needs 8 bits after re-arm
        @(negedge clk); two_byte = 1'b0; sync_lo = 8'h00;
        rearm();
        send_bits(16'h0000, 7);
        chk("R6 seen count reset", synced, 0);
        send_bit(1'b0);
        chk("R6 lock after 8 bits", synced, 1);

        // R4: word repeated after lock is data; R11 idle cycles
        @(negedge clk); two_byte = 1'b1; sync_lo = 8'hD4;
        rearm();
        send_bits(16'h2DD4, 16);
        chk("R4 lock", synced, 1);
        send_bits(16'h2DD4, 16);
        chk("R4 repeat stored", fill_cnt, 16);
        chk("R4 repeat data", rd_data, 8'h2D);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); bit_in = k[0];
        end
        chk("R11 idle count", fill_cnt, 16);
        chk("R11 idle data", rd_data, 8'h2D);
        chk("R4 still locked", synced, 1);
        @(negedge clk); fill_en = 1'b0;
        @(negedge clk);
        chk("R6 clear count", fill_cnt, 0);
        chk("R6 clear synced", synced, 0);

        // R5: bypass does nothing while fill-enable low
        @(negedge clk); always_fill = 1'b1;
        send_bits(16'h00FF, 8);
        chk("R5 disabled no store", fill_cnt, 0);

        // R9 / R7 / R5: every threshold against every count
        for (int t = 0; t <= 16; t++) begin
            @(negedge clk); lvl_thresh = 5'(t);
            rearm();
            for (int n = 0; n <= 16; n++) begin
                if (n > 0) send_bit(n[0]);
                chk("R9 level flag", lvl_irq, (n >= t) ? 1 : 0);
                chk("R7 bypass count", fill_cnt, n);
            end
        end

        // R10 / R8: overflow, short reads, push with pop
        rearm();
        send_bits(16'hBEEF, 16);
        chk("R10 no ovf at full", ovf, 0);
        send_bit(1'b1);
        chk("R10 ovf set", ovf, 1);
        chk("R10 count held", fill_cnt, 16);
        chk("R10 data kept", rd_data, 8'hBE);
        read_byte();
        chk("R8 pop count", fill_cnt, 8);
        chk("R8 next byte", rd_data, 8'hEF);
        chk("R10 ovf sticky", ovf, 1);
        @(negedge clk); bit_in = 1'b1; bit_vld = 1'b1; rd_req = 1'b1;
        @(negedge clk); bit_vld = 1'b0; rd_req = 1'b0;
        chk("R8 push with pop", fill_cnt, 1);
        send_bits(16'h0035, 7);
        chk("R8 byte after push-pop", rd_data, 8'hB5);
        read_byte();
        send_bits(16'h0015, 5);
        read_byte();
        chk("R8 short read ignored", fill_cnt, 5);
        rearm();
        chk("R10 ovf cleared", ovf, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule